// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Controller

This block keeps the machine-mode control and status registers of a 32-bit core: the status word with its interrupt-enable pair, the interrupt-enable mask, the trap vector, the scratch word, the exception PC, the cause word and a free-running 64-bit cycle count. The core reads any of them by a 12-bit address and writes them through a single write port. Reads are combinational, and writes land on the next clock edge.

Each cycle the controller decodes one of three events: none, trap entry or trap return. Trap entry happens when the external interrupt line is high and both the global enable and the external-interrupt mask bit are set. It saves the current PC, records the cause and closes the global enable. Trap return follows a valid return instruction. It reopens the enable from its saved copy. The same decode drives a next-PC selector with five outcomes: trap vector, saved exception PC, hold, jump target and sequential PC+4.

Top module: `mtrap_ctrl`

## Requirements
- R1: Reads are combinational by address: 0x300 status, 0x304 interrupt mask, 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0xC00 cycle bits 31:0, 0xC80 cycle bits 63:32. Any other address reads 0.
- R2: A core write lands at the next edge. The trap vector and exception PC store the data with bits 1:0 cleared. In the status word only bit 3 (global enable) and bit 7 (saved enable) are writable. Bits 12:11 always read 1 and every other bit reads 0.
- R3: The cycle counter adds one on every clock after reset. Core writes to 0xC00 and 0xC80 have no effect.
- R4: An interrupt is taken only when `irq_ext`, status bit 3 and mask bit 11 are all 1. Otherwise the line has no effect.
- R5: On trap entry the exception PC takes `pc_i`, the cause becomes 0x8000000B, bit 7 takes the old bit 3, and bit 3 clears.
- R6: In a trap-entry cycle `next_pc` equals the trap vector in that same cycle.
- R7: In a trap-entry cycle, core writes to the status, exception PC or cause registers are dropped. Core writes to the other registers still land.
- R8: A valid return instruction copies bit 7 into bit 3, sets bit 7, and makes `next_pc` the exception PC in that cycle.
- R9: `next_pc` priority is interrupt, then return, then jump target, then `pc_i + 4`, with 32-bit wrap.
- R10: With `instr_valid` low, `next_pc` equals `pc_i` unless an interrupt is taken, and the return and jump inputs are ignored.
- R11: Reset values: status reads 0x1800, trap vector 0x100, and all other registers and the counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address for read and write |
| csr_wdata | input | 32 | Write data from the core |
| csr_we | input | 1 | Core write strobe |
| irq_ext | input | 1 | External interrupt request |
| mret_i | input | 1 | Current instruction is a trap return |
| pc_i | input | 32 | PC of the current instruction |
| instr_valid | input | 1 | Current instruction is valid |
| jump_taken | input | 1 | Jump or branch taken |
| jump_target | input | 32 | Jump or branch destination |
| csr_rdata | output | 32 | Read data for `csr_addr` |
| next_pc | output | 32 | PC for the following cycle |

## Verification
`next_pc` and `csr_rdata` are combinational. They are due in the same cycle as their inputs, so the bench drives at a falling edge, samples 2 ns later and clears the stimulus before the rising edge. Every register effect (core write, trap entry, return) is due one rising edge after the stimulus, and the bench reads it back through `csr_rdata` after the following falling edge. For the cycle counter, the expected difference between two reads equals the number of falling edges the bench waited between them.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam logic [11:0] ADDR_STATUS  = 12'h300;
    localparam logic [11:0] ADDR_IMASK   = 12'h304;
    localparam logic [11:0] ADDR_TVEC    = 12'h305;
    localparam logic [11:0] ADDR_SCRATCH = 12'h340;
    localparam logic [11:0] ADDR_EPC     = 12'h341;
    localparam logic [11:0] ADDR_CAUSE   = 12'h342;
    localparam logic [11:0] ADDR_CYC_LO  = 12'hC00;
    localparam logic [11:0] ADDR_CYC_HI  = 12'hC80;

    localparam int GIE_BIT  = 3;
    localparam int SGIE_BIT = 7;
    localparam int PRV_LO   = 11;
    localparam int PRV_HI   = 12;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_TRAP,
        EV_RETURN
    } trap_ev_e;

    typedef enum logic [2:0] {
        NPC_SEQ,
        NPC_JUMP,
        NPC_TRAP,
        NPC_RET,
        NPC_HOLD
    } npc_sel_e;

endpackage

// File: rtl/mtrap_cycle_ctr.sv
module mtrap_cycle_ctr #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    assign count = cnt_q;

    // R3: counter advances by exactly one per clock
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/mtrap_csr_regs.sv
module mtrap_csr_regs
    import mtrap_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          IRQ_CODE    = 11,
    parameter logic [31:0] TVEC_RESET  = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trap_ev_e          ev,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [2*XLEN-1:0] cycle_cnt,
    output logic [XLEN-1:0]   rd_data,
    output logic [XLEN-1:0]   tvec_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              gie_o,
    output logic              ext_en_o
);

    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);
    localparam logic [XLEN-1:0] CAUSE_VAL  = {1'b1, (XLEN-1)'(IRQ_CODE)};

    logic            gie_q, sgie_q;
    logic [XLEN-1:0] imask_q, tvec_q, scratch_q, epc_q, cause_q;

    logic wr_status, wr_imask, wr_tvec, wr_scratch, wr_epc, wr_cause;

    always_comb begin
        wr_status  = csr_we && (csr_addr == ADDR_STATUS);
        wr_imask   = csr_we && (csr_addr == ADDR_IMASK);
        wr_tvec    = csr_we && (csr_addr == ADDR_TVEC);
        wr_scratch = csr_we && (csr_addr == ADDR_SCRATCH);
        wr_epc     = csr_we && (csr_addr == ADDR_EPC);
        wr_cause   = csr_we && (csr_addr == ADDR_CAUSE);
    end

    // status pair: trap entry and return take precedence over core writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            sgie_q <= 1'b0;
        end else begin
            unique case (ev)
                EV_TRAP: begin
                    sgie_q <= gie_q;
                    gie_q  <= 1'b0;
                end
                EV_RETURN: begin
                    gie_q  <= sgie_q;
                    sgie_q <= 1'b1;
                end
                default: begin
                    if (wr_status) begin
                        gie_q  <= csr_wdata[GIE_BIT];
                        sgie_q <= csr_wdata[SGIE_BIT];
                    end
                end
            endcase
        end
    end

    // exception PC and cause: trap entry overrides the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (ev == EV_TRAP) begin
            epc_q   <= pc_i & ALIGN_MASK;
            cause_q <= CAUSE_VAL;
        end else begin
            if (wr_epc)   epc_q   <= csr_wdata & ALIGN_MASK;
            if (wr_cause) cause_q <= csr_wdata;
        end
    end

    // registers the trap logic never touches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q   <= '0;
            tvec_q    <= XLEN'(TVEC_RESET) & ALIGN_MASK;
            scratch_q <= '0;
        end else begin
            if (wr_imask)   imask_q   <= csr_wdata;
            if (wr_tvec)    tvec_q    <= csr_wdata & ALIGN_MASK;
            if (wr_scratch) scratch_q <= csr_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        case (csr_addr)
            ADDR_STATUS: begin
                rd_data[GIE_BIT]  = gie_q;
                rd_data[SGIE_BIT] = sgie_q;
                rd_data[PRV_LO]   = 1'b1;
                rd_data[PRV_HI]   = 1'b1;
            end
            ADDR_IMASK:   rd_data = imask_q;
            ADDR_TVEC:    rd_data = tvec_q;
            ADDR_SCRATCH: rd_data = scratch_q;
            ADDR_EPC:     rd_data = epc_q;
            ADDR_CAUSE:   rd_data = cause_q;
            ADDR_CYC_LO:  rd_data = cycle_cnt[XLEN-1:0];
            ADDR_CYC_HI:  rd_data = cycle_cnt[2*XLEN-1:XLEN];
            default:      rd_data = '0;
        endcase
    end

    assign tvec_o   = tvec_q;
    assign epc_o    = epc_q;
    assign gie_o    = gie_q;
    assign ext_en_o = imask_q[IRQ_CODE];

    // R5: trap entry state update
    p_trap_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP) |=> (epc_q == ($past(pc_i) & ALIGN_MASK)) &&
                            (cause_q == CAUSE_VAL) && !gie_q &&
                            (sgie_q == $past(gie_q)));

    // R7: a concurrent core write to the exception PC loses to trap entry
    p_trap_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP && wr_epc) |=> epc_q == ($past(pc_i) & ALIGN_MASK));

    // R8: return restores the enable and sets the saved copy
    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RETURN) |=> (gie_q == $past(sgie_q)) && sgie_q);

    // R2: scratch takes the written word
    p_scratch_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_scratch |=> scratch_q == $past(csr_wdata));

endmodule

// File: rtl/mtrap_npc.sv
module mtrap_npc
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  trap_ev_e        ev,
    input  logic            instr_valid,
    input  logic            jump_taken,
    input  logic [XLEN-1:0] jump_target,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] tvec,
    input  logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] next_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    npc_sel_e sel;

    always_comb begin
        if (ev == EV_TRAP)        sel = NPC_TRAP;
        else if (ev == EV_RETURN) sel = NPC_RET;
        else if (!instr_valid)    sel = NPC_HOLD;
        else if (jump_taken)      sel = NPC_JUMP;
        else                      sel = NPC_SEQ;
    end

    always_comb begin
        unique case (sel)
            NPC_TRAP: next_pc = tvec;
            NPC_RET:  next_pc = epc;
            NPC_HOLD: next_pc = pc_i;
            NPC_JUMP: next_pc = jump_target;
            default:  next_pc = pc_i + STEP;
        endcase
    end

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          IRQ_CODE   = 11,
    parameter logic [31:0] TVEC_RESET = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_we,
    input  logic            irq_ext,
    input  logic            mret_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            instr_valid,
    input  logic            jump_taken,
    input  logic [XLEN-1:0] jump_target,
    output logic [XLEN-1:0] csr_rdata,
    output logic [XLEN-1:0] next_pc
);

    localparam int CYC_W = 2 * XLEN;

    logic [CYC_W-1:0] cycle_cnt;
    logic [XLEN-1:0]  tvec, epc;
    logic             gie, ext_en;
    trap_ev_e         ev;

    always_comb begin
        if (irq_ext && gie && ext_en)     ev = EV_TRAP;
        else if (mret_i && instr_valid)   ev = EV_RETURN;
        else                              ev = EV_NONE;
    end

    mtrap_cycle_ctr #(.CNT_W(CYC_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_cnt)
    );

    mtrap_csr_regs #(
        .XLEN       (XLEN),
        .IRQ_CODE   (IRQ_CODE),
        .TVEC_RESET (TVEC_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .pc_i      (pc_i),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .cycle_cnt (cycle_cnt),
        .rd_data   (csr_rdata),
        .tvec_o    (tvec),
        .epc_o     (epc),
        .gie_o     (gie),
        .ext_en_o  (ext_en)
    );

    mtrap_npc #(.XLEN(XLEN)) u_npc (
        .ev          (ev),
        .instr_valid (instr_valid),
        .jump_taken  (jump_taken),
        .jump_target (jump_target),
        .pc_i        (pc_i),
        .tvec        (tvec),
        .epc         (epc),
        .next_pc     (next_pc)
    );

    // R6: trap entry redirects to the vector in the same cycle
    p_trap_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP) |-> next_pc == tvec);

    // R10: an invalid instruction without interrupt holds the PC
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && ev == EV_NONE) |-> next_pc == pc_i);

    // R8: a return selects the saved exception PC
    p_ret_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RETURN) |-> next_pc == epc);

    // R4: with the global enable clear, no trap is recorded
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && irq_ext) |=> $stable(epc) || $past(csr_we));

endmodule

// File: tb/mtrap_ctrl_bench.sv
module mtrap_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata;
    logic        csr_we;
    logic        irq_ext;
    logic        mret_i;
    logic [31:0] pc_i;
    logic        instr_valid;
    logic        jump_taken;
    logic [31:0] jump_target;
    logic [31:0] csr_rdata;
    logic [31:0] next_pc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mtrap_ctrl u_mtrap_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .csr_we      (csr_we),
        .irq_ext     (irq_ext),
        .mret_i      (mret_i),
        .pc_i        (pc_i),
        .instr_valid (instr_valid),
        .jump_taken  (jump_taken),
        .jump_target (jump_target),
        .csr_rdata   (csr_rdata),
        .next_pc     (next_pc)
    );

    // selector codes: 0 seq, 1 jump, 2 vector, 3 saved PC, 4 hold
    typedef struct packed {
        logic        irq;
        logic        ret;
        logic        valid;
        logic        jmp;
        logic [31:0] pc;
        logic [31:0] tgt;
        logic [2:0]  sel;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_2000, 3'd0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_2000, 3'd1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_2000, 3'd2},
        '{1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_2000, 3'd2},
        '{1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_2000, 3'd3},
        '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_1008, 32'h0000_2000, 3'd4},
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_100C, 32'h0000_2000, 3'd4},
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1010, 32'h0000_2000, 3'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'h0000_2000, 3'd0}
    };

    localparam logic [31:0] TV = 32'h0000_0200;
    localparam logic [31:0] EP = 32'h0000_0400;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr  = a;
        csr_wdata = d;
        csr_we    = 1'b1;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic idle();
        irq_ext     = 1'b0;
        mret_i      = 1'b0;
        instr_valid = 1'b1;
        jump_taken  = 1'b0;
        csr_we      = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        logic [31:0] exp;
        rst_n = 1'b0;
        csr_addr = '0;
        csr_wdata = '0;
        pc_i = 32'h0000_1000;
        jump_target = '0;
        idle();
        repeat (2) @(negedge clk);
        // R11 reset values
        rd(12'h300, v); chk("R11 status", v, 32'h0000_1800);
        rd(12'h305, v); chk("R11 tvec", v, 32'h0000_0100);
        rd(12'h341, v); chk("R11 epc", v, 32'h0);
        rd(12'hC00, v); chk("R11 cycle", v, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 write masks; R1 unknown addresses
        wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, v); chk("R2 status mask", v, 32'h0000_1888);
        wr(12'h305, 32'h0000_0201); rd(12'h305, v); chk("R2 tvec align", v, TV);
        wr(12'h341, 32'h0000_0403); rd(12'h341, v); chk("R2 epc align", v, EP);
        wr(12'h342, 32'h1234_5678); rd(12'h342, v); chk("R2 cause", v, 32'h1234_5678);
        wr(12'h304, 32'h0000_0800); rd(12'h304, v); chk("R1 imask", v, 32'h0000_0800);
        rd(12'h123, v); chk("R1 unknown", v, 32'h0);
        rd(12'h301, v); chk("R1 near miss", v, 32'h0);

        // R5/R6/R7 trap with a simultaneous core write to epc
        @(negedge clk);
        irq_ext = 1'b1; pc_i = 32'h0000_1234;
        csr_addr = 12'h341; csr_wdata = 32'h0000_5550; csr_we = 1'b1;
        #2 chk("R6 vector now", next_pc, TV);
        @(negedge clk); idle();
        rd(12'h341, v); chk("R7 epc kept from trap", v, 32'h0000_1234);
        rd(12'h342, v); chk("R5 cause", v, 32'h8000_000B);
        rd(12'h300, v); chk("R5 status", v, 32'h0000_1880);

        // R4 interrupt masked by cleared global enable
        @(negedge clk);
        irq_ext = 1'b1;
        #2 chk("R4 global gate", next_pc, 32'h0000_1238);
        #3 idle();

        // R8 return
        @(negedge clk);
        mret_i = 1'b1; pc_i = 32'h0000_3000;
        #2 chk("R8 return pc", next_pc, 32'h0000_1234);
        @(negedge clk); idle();
        rd(12'h300, v); chk("R8 status", v, 32'h0000_1888);

        // R7 non-protected register still written during trap
        @(negedge clk);
        irq_ext = 1'b1; csr_addr = 12'h340; csr_wdata = 32'h0000_00AA; csr_we = 1'b1;
        @(negedge clk); idle();
        rd(12'h340, v); chk("R7 scratch lands", v, 32'h0000_00AA);
        rd(12'h300, v); chk("R7 status", v, 32'h0000_1880);

        // R10 invalid return ignored
        @(negedge clk);
        instr_valid = 1'b0; mret_i = 1'b1;
        @(negedge clk); idle();
        rd(12'h300, v); chk("R10 invalid return", v, 32'h0000_1880);

        // reopen enable, then R4 mask bit gate
        @(negedge clk); mret_i = 1'b1;
        @(negedge clk); idle();
        wr(12'h304, 32'h0);
        @(negedge clk);
        irq_ext = 1'b1; pc_i = 32'h0000_1000;
        #2 chk("R4 mask gate", next_pc, 32'h0000_1004);
        #3 idle();
        wr(12'h304, 32'h0000_0800);
        wr(12'h341, 32'h0000_0403);

        // R9/R10 priority table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            irq_ext = TBL[i].irq; mret_i = TBL[i].ret;
            instr_valid = TBL[i].valid; jump_taken = TBL[i].jmp;
            pc_i = TBL[i].pc; jump_target = TBL[i].tgt;
            case (TBL[i].sel)
                3'd0: exp = TBL[i].pc + 32'd4;
                3'd1: exp = TBL[i].tgt;
                3'd2: exp = TV;
                3'd3: exp = EP;
                default: exp = TBL[i].pc;
            endcase
            #2 chk($sformatf("R9 table row %0d", i), next_pc, exp);
            #3 idle();
        end

        // R3 cycle counter
        @(negedge clk);
        rd(12'hC00, a);
        repeat (5) @(negedge clk);
        rd(12'hC00, b);
        chk("R3 step", b - a, 32'd5);
        rd(12'hC80, v); chk("R3 high", v, 32'h0);
        wr(12'hC00, 32'hFFFF_FFF0);
        rd(12'hC00, v); chk("R3 write ignored", v, b + 32'd2);

        wr(12'h300, 32'h0);
        rd(12'h300, v); chk("R2 status clear", v, 32'h0000_1800);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule